// File: doc/BRIEF.md
# Calibrated One-Second Prescaler with Periodic Trim

This block turns a nominal 32,768 Hz oscillator, delivered as a single-cycle enable on the system clock, into a one-second tick and a minute marker. A two-stage divider does the counting. The lower stage divides by 256, and the upper stage counts those stage pulses up to one second. Two further counters track the seconds within a minute and the minutes within a 64-minute correction cycle.

Accuracy is trimmed by a 5-bit step count and a direction bit. When the step count is N, the first second of each of the first 2·N minutes of the cycle is corrected. A faster setting adds a whole stage worth of counts, 256, so that second ends early. A slower setting blanks half a stage, 128 counts, so that second ends late. Each step is therefore worth about +4.068 ppm or −2.034 ppm. The trim setting is captured only at minute boundaries, so a change applies from the next minute on. A stop input holds the whole divider cleared.

Top module: `cal_prescaler`

## Requirements
- R1: When untrimmed, a second lasts exactly CYC_PER_SEC (default 32768) clock cycles in which `osc_en` is high; cycles with `osc_en` low do not advance the divider.
- R2: With `cal_steps` = 0, every second is exactly CYC_PER_SEC enables long, whatever the value of `cal_faster`.
- R3: With `cal_faster` = 1 and `cal_steps` = N > 0, the first second (second index 0) of each trimmed minute lasts CYC_PER_SEC − STAGE_DIV enables (default 32512).
- R4: With `cal_faster` = 0 and `cal_steps` = N > 0, the first second of each trimmed minute lasts CYC_PER_SEC + STAGE_DIV/2 enables (default 32896).
- R5: Minute indices 0 to 2·N−1 of the MIN_PER_CYCLE-minute cycle are trimmed, and all other minutes are untouched. With N = 31, minutes 62 and 63 are untouched. The minute index returns to 0 after the last minute, and trimming then repeats.
- R6: The trim setting is captured while reset or stop is asserted and at each minute boundary. A change in the middle of a minute has no effect until the next minute begins.
- R7: `min_tick` is high exactly on the `sec_tick` that ends the last second (index SEC_PER_MIN−1) of each minute, and at no other time.
- R8: While `stop` is high, all counters are held cleared and no tick is emitted. After `stop` falls, the first second is counted in full from the release.
- R9: `sec_tick` is a one-cycle pulse. It is raised in the cycle after the edge that consumes the completing enable.
- R10: Under reset, both `sec_tick` and `min_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| stop | input | 1 | Holds the divider cleared while high |
| cal_steps | input | 5 | Trim magnitude N, binary 0 to 31 |
| cal_faster | input | 1 | Trim direction: 1 shortens seconds, 0 lengthens them |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse with the last second of each minute |

## Verification
The bench builds the block with a 32-enable second, a stage of 8, and a 4-second minute, and keeps the 64-minute cycle at full length. Under these values a trimmed second lasts 24 or 36 cycles, and a whole correction cycle runs in about 8k cycles. The bench can therefore walk past minute 62 with the largest trim, where correction must stop, and on through the wrap back to minute 0. The short minute also lets it check capture at the boundary, the release from stop, and half-rate enables with only a few seconds of stimulus each.

// File: rtl/cal_prescale_pkg.sv
`timescale 1ns/1ps
package cal_prescale_pkg;

    localparam int CAL_MAG_W = 5;

    // Trim setting as captured at a minute boundary
    typedef struct packed {
        logic                 faster;
        logic [CAL_MAG_W-1:0] steps;
    } cal_setting_t;

    // Correction requests for the current stage of the current second
    typedef struct packed {
        logic split;    // skip one stage pulse (second ends early)
        logic stretch;  // extend this stage by half a stage (second ends late)
    } corr_t;

    // A minute is trimmed when its index is below twice the step count
    function automatic logic minute_is_trimmed(input logic [CAL_MAG_W-1:0] steps,
                                               input int unsigned          minute_idx);
        return minute_idx < (32'(steps) << 1);
    endfunction

endpackage

// File: rtl/cal_stage_div.sv
`timescale 1ns/1ps
module cal_stage_div #(
    parameter int STAGE_DIV = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick_en,
    input  logic stretch,
    output logic stage_done
);
    localparam int LONG_DIV = STAGE_DIV + STAGE_DIV / 2;
    localparam int LO_W     = $clog2(LONG_DIV);

    logic [LO_W-1:0] lo_cnt;
    logic [LO_W-1:0] lo_term;

    always_comb begin
        lo_term    = stretch ? LO_W'(LONG_DIV - 1) : LO_W'(STAGE_DIV - 1);
        stage_done = tick_en && (lo_cnt >= lo_term);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_cnt <= '0;
        end else if (tick_en) begin
            if (lo_cnt >= lo_term) lo_cnt <= '0;
            else                   lo_cnt <= lo_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cal_sec_div.sv
`timescale 1ns/1ps
module cal_sec_div #(
    parameter int HI_DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stage_done,
    input  logic split,
    output logic sec_done,
    output logic first_stage
);
    localparam int HI_W = $clog2(HI_DIV);

    logic [HI_W-1:0] hi_cnt;

    always_comb begin
        first_stage = (hi_cnt == '0);
        sec_done    = stage_done && (hi_cnt >= HI_W'(HI_DIV - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hi_cnt <= '0;
        end else if (stage_done) begin
            if (hi_cnt >= HI_W'(HI_DIV - 1))
                hi_cnt <= '0;
            else if (split && first_stage)
                hi_cnt <= HI_W'(2);
            else
                hi_cnt <= hi_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cal_sched.sv
`timescale 1ns/1ps
module cal_sched
    import cal_prescale_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         sec_done,
    input  logic         first_stage,
    input  cal_setting_t cal_in,
    output corr_t        corr,
    output logic         min_done
);
    localparam int SEC_W = $clog2(SEC_PER_MIN);
    localparam int MIN_W = $clog2(MIN_PER_CYCLE);

    logic [SEC_W-1:0] sec_idx;
    logic [MIN_W-1:0] min_idx;
    cal_setting_t     cal_q;
    logic             last_sec;
    logic             trimmed;

    always_comb begin
        last_sec     = (sec_idx == SEC_W'(SEC_PER_MIN - 1));
        min_done     = sec_done && last_sec;
        trimmed      = (sec_idx == '0) && minute_is_trimmed(cal_q.steps, 32'(min_idx));
        corr.split   = trimmed && first_stage &&  cal_q.faster;
        corr.stretch = trimmed && first_stage && !cal_q.faster;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sec_idx <= '0;
            min_idx <= '0;
            cal_q   <= cal_in;
        end else if (sec_done) begin
            if (last_sec) begin
                sec_idx <= '0;
                cal_q   <= cal_in;
                if (min_idx == MIN_W'(MIN_PER_CYCLE - 1)) min_idx <= '0;
                else                                      min_idx <= min_idx + 1'b1;
            end else begin
                sec_idx <= sec_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler
    import cal_prescale_pkg::*;
#(
    parameter int CYC_PER_SEC   = 32768,
    parameter int STAGE_DIV     = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 osc_en,
    input  logic                 stop,
    input  logic [CAL_MAG_W-1:0] cal_steps,
    input  logic                 cal_faster,
    output logic                 sec_tick,
    output logic                 min_tick
);
    localparam int HI_DIV = CYC_PER_SEC / STAGE_DIV;

    cal_setting_t cal_in;
    corr_t        corr;
    logic         stage_done;
    logic         sec_done;
    logic         first_stage;
    logic         min_done;

    assign cal_in = '{faster: cal_faster, steps: cal_steps};

    cal_stage_div #(.STAGE_DIV(STAGE_DIV)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .clr        (stop),
        .tick_en    (osc_en),
        .stretch    (corr.stretch),
        .stage_done (stage_done)
    );

    cal_sec_div #(.HI_DIV(HI_DIV)) u_sec (
        .clk         (clk),
        .rst         (rst),
        .clr         (stop),
        .stage_done  (stage_done),
        .split       (corr.split),
        .sec_done    (sec_done),
        .first_stage (first_stage)
    );

    cal_sched #(
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .clr         (stop),
        .sec_done    (sec_done),
        .first_stage (first_stage),
        .cal_in      (cal_in),
        .corr        (corr),
        .min_done    (min_done)
    );

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            sec_tick <= 1'b0;
            min_tick <= 1'b0;
        end else begin
            sec_tick <= sec_done;
            min_tick <= min_done;
        end
    end
endmodule

// File: rtl/cal_prescaler_chk.sv
`timescale 1ns/1ps
module cal_prescaler_chk #(
    parameter int CYC_PER_SEC   = 32768,
    parameter int STAGE_DIV     = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input logic clk,
    input logic rst,
    input logic osc_en,
    input logic stop,
    input logic sec_tick,
    input logic min_tick
);
    localparam int MAX_LEN = CYC_PER_SEC + STAGE_DIV / 2;
    localparam int MIN_LEN = CYC_PER_SEC - STAGE_DIV;
    localparam int LEN_W   = $clog2(MAX_LEN + 2) + 1;
    localparam int SC_W    = $clog2(SEC_PER_MIN + 1) + 1;

    logic [LEN_W-1:0] en_cnt;
    logic [SC_W-1:0]  secs_in_min;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            en_cnt      <= '0;
            secs_in_min <= '0;
        end else begin
            if (sec_tick)    en_cnt <= LEN_W'(osc_en);
            else if (osc_en) en_cnt <= en_cnt + 1'b1;
            if (min_tick)      secs_in_min <= '0;
            else if (sec_tick) secs_in_min <= secs_in_min + 1'b1;
        end
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst) sec_tick |=> !sec_tick);

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst) stop |=> (!sec_tick && !min_tick));

    // R7
    min_with_sec_chk: assert property (@(posedge clk) disable iff (rst) min_tick |-> sec_tick);

    // R7
    min_len_chk: assert property (@(posedge clk) disable iff (rst)
        min_tick |-> (secs_in_min == SC_W'(SEC_PER_MIN - 1)));

    // R1
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst) !osc_en |=> !sec_tick);

    // R3
    sec_len_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (en_cnt >= LEN_W'(MIN_LEN) && en_cnt <= LEN_W'(MAX_LEN)));

    // R4
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst) en_cnt <= LEN_W'(MAX_LEN));
endmodule

bind cal_prescaler cal_prescaler_chk #(
    .CYC_PER_SEC   (CYC_PER_SEC),
    .STAGE_DIV     (STAGE_DIV),
    .SEC_PER_MIN   (SEC_PER_MIN),
    .MIN_PER_CYCLE (MIN_PER_CYCLE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_en   (osc_en),
    .stop     (stop),
    .sec_tick (sec_tick),
    .min_tick (min_tick)
);

// File: tb/cal_prescaler_test.sv
`timescale 1ns/1ps
module cal_prescaler_test;
    localparam int CYC  = 32;
    localparam int STG  = 8;
    localparam int SPM  = 4;
    localparam int MPC  = 64;
    localparam int NOM  = CYC;
    localparam int FAST = CYC - STG;
    localparam int SLOW = CYC + STG / 2;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b1;
    logic       stop = 1'b0;
    logic [4:0] cal_steps = '0;
    logic       cal_faster = 1'b0;
    logic       sec_tick;
    logic       min_tick;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit half_rate = 1'b0;
    bit done = 1'b0;

    cal_prescaler #(
        .CYC_PER_SEC   (CYC),
        .STAGE_DIV     (STG),
        .SEC_PER_MIN   (SPM),
        .MIN_PER_CYCLE (MPC)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .osc_en     (osc_en),
        .stop       (stop),
        .cal_steps  (cal_steps),
        .cal_faster (cal_faster),
        .sec_tick   (sec_tick),
        .min_tick   (min_tick)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (half_rate) osc_en <= ~osc_en;
        else           osc_en <= 1'b1;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic next_sec(output int len, output int mflag);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!sec_tick && len < 1000);
        mflag = int'(min_tick);
    endtask

    task automatic do_reset(input int steps, input bit faster);
        @(negedge clk);
        rst = 1'b1;
        stop = 1'b0;
        half_rate = 1'b0;
        cal_steps = 5'(steps);
        cal_faster = faster;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_minutes(input int steps, input bit faster, input int nmin, input string req);
        int len;
        int mf;
        do_reset(steps, faster);
        for (int m = 0; m < nmin; m++) begin
            for (int s = 0; s < SPM; s++) begin
                int exp_len;
                exp_len = (s == 0 && (m % MPC) < 2 * steps) ? (faster ? FAST : SLOW) : NOM;
                next_sec(len, mf);
                check(req, len, exp_len, $sformatf("second length min %0d sec %0d", m, s));
                check("R7", mf, (s == SPM - 1) ? 1 : 0, $sformatf("minute marker min %0d sec %0d", m, s));
            end
        end
    endtask

    // R10
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", int'(sec_tick), 0, "sec_tick under reset");
        check("R10", int'(min_tick), 0, "min_tick under reset");
    endtask

    // R1 R2
    task automatic t_nominal();
        run_minutes(0, 1'b1, 2, "R2");
        run_minutes(0, 1'b0, 2, "R2");
        run_minutes(0, 1'b0, 1, "R1");
    endtask

    // R3
    task automatic t_fast();
        run_minutes(1, 1'b1, 4, "R3");
    endtask

    // R4
    task automatic t_slow();
        run_minutes(6, 1'b0, 14, "R4");
    endtask

    // R5: largest trim, past minute 62 and through the wrap
    task automatic t_full_cycle();
        run_minutes(31, 1'b1, MPC + 2, "R5");
    endtask

    // R6: change mid-minute applies from the next minute
    task automatic t_change();
        int len;
        int mf;
        do_reset(0, 1'b0);
        next_sec(len, mf);
        check("R6", len, NOM, "second before change");
        cal_steps = 5'd2;
        cal_faster = 1'b1;
        for (int s = 1; s < SPM; s++) begin
            next_sec(len, mf);
            check("R6", len, NOM, $sformatf("rest of minute 0 sec %0d", s));
        end
        for (int m = 1; m < 5; m++) begin
            next_sec(len, mf);
            check("R6", len, (m < 4) ? FAST : NOM, $sformatf("first second of minute %0d", m));
            for (int s = 1; s < SPM; s++) next_sec(len, mf);
        end
    endtask

    // R9
    task automatic t_pulse();
        int len;
        int mf;
        do_reset(0, 1'b0);
        next_sec(len, mf);
        check("R9", len, NOM, "tick cycle after reset");
        @(negedge clk);
        check("R9", int'(sec_tick), 0, "tick width");
    endtask

    // R8 R6: stop clears, captures trim, first second counted from release
    task automatic t_stop();
        int len;
        int mf;
        int seen;
        do_reset(0, 1'b0);
        next_sec(len, mf);
        repeat (10) @(negedge clk);
        stop = 1'b1;
        cal_steps = 5'd1;
        cal_faster = 1'b1;
        seen = 0;
        for (int i = 0; i < 3 * CYC; i++) begin
            @(negedge clk);
            if (sec_tick || min_tick) seen++;
        end
        check("R8", seen, 0, "ticks while stopped");
        stop = 1'b0;
        next_sec(len, mf);
        check("R8", len, FAST, "first second after release with new trim");
        next_sec(len, mf);
        check("R8", len, NOM, "second second after release");
    endtask

    // R1: enables at half rate double the cycle count
    task automatic t_half_rate();
        int len;
        int mf;
        do_reset(0, 1'b0);
        half_rate = 1'b1;
        next_sec(len, mf);
        next_sec(len, mf);
        check("R1", len, 2 * NOM, "second length at half-rate enable");
        next_sec(len, mf);
        check("R1", len, 2 * NOM, "next second at half-rate enable");
        half_rate = 1'b0;
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_fast();
        t_slow();
        t_full_cycle();
        t_change();
        t_pulse();
        t_stop();
        t_half_rate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule